// File: doc/BRIEF.md
# Four-Channel Pulse-Width-Coded Motor Command Transmitter

This block drives four motor-control serial lines from a single shared timebase. Each line carries repeated 16-bit frames. A frame holds an 11-bit throttle or command value, a telemetry-request bit that is always sent as zero, and a 4-bit check nibble. Each bit takes a fixed number of clocks. The line rises at the start of every bit slot and falls early for a zero and late for a one. The line stays low for a configurable gap between frames.

Upstream logic presents all four values on one wide bus and pulses a load strobe. The values land in a back buffer. At the next frame boundary the back buffer becomes the front buffer, so a frame already on the wire is never changed part-way. Several loads within one frame leave only the newest set. A one-cycle done pulse marks the end of each frame, so software or a sequencer can pace its updates.

Top module: `dshot_quad_tx`

## Requirements
- R1: Each frame is 16 bit slots sent most significant first. Slots 0 to 10 carry the 11-bit value, from value bit 10 down to value bit 0.
- R2: Slot 11 (the telemetry-request bit) is always sent as a zero.
- R3: Slots 12 to 15 carry the check nibble c3..c0, where c = ~(x ^ (x >> 4) ^ (x >> 8)) & 0xF and x is the 11-bit value shifted left by 5.
- R4: A bit slot lasts BIT_PERIOD clocks (default 280). The line is high for the first HIGH_ONE clocks (default 210) for a one and HIGH_ZERO clocks (default 105) for a zero, and low for the rest of the slot.
- R5: All four lines share one timebase, so every bit slot starts in the same clock on every channel.
- R6: After reset, and after every frame, each line is held low for IDLE_BITS bit periods (default 32) before the next frame starts.
- R7: A load strobe writes `load_values` (channel c in bits [11c+10:11c]) into the back buffer. The new values are first sent in the frame that starts after the load, and a frame already in progress is unchanged.
- R8: When several loads arrive before a frame boundary, the frame after the boundary carries only the most recent values.
- R9: A load sampled in the last clock of an idle gap belongs to the following frame. The frame that starts at the next clock still carries the earlier values.
- R10: `frame_done` is high for exactly one clock, the first clock after the last bit slot of each frame, and is low at all other times.
- R11: While reset is held, every line and `frame_done` are low and both buffers are cleared. The first frame after reset therefore carries value 0 with check nibble 0xF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Strobe that captures `load_values` into the back buffer |
| load_values | input | NUM_CH*11 | Four 11-bit values; channel c in bits [11c+10:11c] |
| dshot_out | output | NUM_CH | Serial output lines, one per channel |
| frame_done | output | 1 | One-clock pulse after each completed frame |

## Verification
The line level is decoded from registered state, so it matches the state of the same cycle. The bench therefore compares it with a behavioural model on every falling edge. A load sampled at a rising edge can first reach the wire at the first clock of the next frame. The model copies its back store only at that boundary edge, and it takes a same-edge load only after the copy. `frame_done` is due in the clock after the last slot, at the first position of the next period. In addition, each frame is decoded from the wire mid-slot and compared at that pulse with the value the test sequence expects.

// File: rtl/dshot_pkg.sv
// Package: shared frame constants and the check-nibble function for the
// four-channel pulse-width-coded transmitter.
// Assumes an 11-bit value field, one telemetry-request bit and a 4-bit nibble.
package dshot_pkg;

    localparam int VAL_W      = 11;
    localparam int CHK_W      = 4;
    localparam int FRAME_BITS = VAL_W + 1 + CHK_W;
    localparam logic TLM_REQ  = 1'b0;

    typedef logic [VAL_W-1:0]      dval_t;
    typedef logic [FRAME_BITS-1:0] dframe_t;

    // Inverted XOR of three nibbles of the value shifted into frame position.
    function automatic logic [CHK_W-1:0] chk_nibble(input dval_t v, input logic tlm);
        logic [15:0] x;
        x = {v, tlm, 4'b0000};
        return ~(x[3:0] ^ x[7:4] ^ x[11:8]);
    endfunction

    // Whole frame: value, telemetry bit, check nibble, MSB sent first.
    function automatic dframe_t build_frame(input dval_t v);
        return {v, TLM_REQ, chk_nibble(v, TLM_REQ)};
    endfunction

endpackage

// File: rtl/dshot_timebase.sv
// Module: dshot_timebase
// Shared slot/bit counter for all channels. Alternates between an idle gap of
// IDLE_BITS bit periods and a frame of FRAME_BITS bit periods, starting idle.
// Assumes BIT_PERIOD >= 2 and IDLE_BITS >= 1.
module dshot_timebase
    import dshot_pkg::*;
#(
    parameter int BIT_PERIOD = 280,
    parameter int IDLE_BITS  = 32,
    parameter int SLOT_W     = $clog2(BIT_PERIOD),
    parameter int BIT_W      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] slot,
    output logic              in_frame,
    output logic              bit_adv,
    output logic              start_evt,
    output logic              end_evt
);

    localparam logic [SLOT_W-1:0] SLOT_LAST  = SLOT_W'(BIT_PERIOD - 1);
    localparam logic [BIT_W-1:0]  IDLE_LAST  = BIT_W'(IDLE_BITS - 1);
    localparam logic [BIT_W-1:0]  FRAME_LAST = BIT_W'(FRAME_BITS - 1);

    logic [SLOT_W-1:0] slot_q;
    logic [BIT_W-1:0]  bit_q;
    logic              frame_q;

    // Decode end-of-slot, start-of-frame and end-of-frame events.
    always_comb begin
        bit_adv   = (slot_q == SLOT_LAST);
        start_evt = !frame_q && bit_adv && (bit_q == IDLE_LAST);
        end_evt   = frame_q && bit_adv && (bit_q == FRAME_LAST);
    end

    // Advance slot and bit counters; flip phase at the end of gap or frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q  <= '0;
            bit_q   <= '0;
            frame_q <= 1'b0;
        end else if (bit_adv) begin
            slot_q <= '0;
            if (start_evt || end_evt) begin
                bit_q   <= '0;
                frame_q <= !frame_q;
            end else begin
                bit_q <= bit_q + BIT_W'(1);
            end
        end else begin
            slot_q <= slot_q + SLOT_W'(1);
        end
    end

    assign slot     = slot_q;
    assign in_frame = frame_q;

endmodule

// File: rtl/dshot_dbuf.sv
// Module: dshot_dbuf
// Two banks of channel values with a front index. Loads go to the back bank.
// The index flips at a frame start only if a load is pending. A load in the
// start cycle is written to the bank that is back after that flip.
module dshot_dbuf
    import dshot_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int BUS_W  = NUM_CH * VAL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BUS_W-1:0] load_values,
    input  logic             start_evt,
    output logic [BUS_W-1:0] frame_values
);

    logic [BUS_W-1:0] bank_q [2];
    logic             front_q;
    logic             pend_q;
    logic             swap;
    logic             wr_sel;
    logic             rd_sel;

    // Choose which bank is written and which feeds the starting frame.
    always_comb begin
        swap   = start_evt && pend_q;
        wr_sel = swap ? front_q : !front_q;
        rd_sel = swap ? !front_q : front_q;
        frame_values = bank_q[rd_sel];
    end

    // Store loads, track pending data and flip the front index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q[0] <= '0;
            bank_q[1] <= '0;
            front_q   <= 1'b0;
            pend_q    <= 1'b0;
        end else begin
            if (load) begin
                bank_q[wr_sel] <= load_values;
            end
            if (swap) begin
                front_q <= !front_q;
            end
            if (load) begin
                pend_q <= 1'b1;
            end else if (start_evt) begin
                pend_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dshot_frame_enc.sv
// Module: dshot_frame_enc
// Combinational frame assembly for every channel: value, telemetry bit and
// check nibble. Assumes channel c sits in bits [VAL_W*c +: VAL_W].
module dshot_frame_enc
    import dshot_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic [NUM_CH*VAL_W-1:0]      values,
    output logic [NUM_CH*FRAME_BITS-1:0] frames
);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        // Build one channel's 16-bit frame.
        always_comb begin
            frames[ch*FRAME_BITS +: FRAME_BITS] = build_frame(values[ch*VAL_W +: VAL_W]);
        end
    end

endmodule

// File: rtl/dshot_bit_shaper.sv
// Module: dshot_bit_shaper
// Holds a shift register per channel, loaded at frame start and shifted at
// each slot end. Each line is high while the slot count is below the compare
// value picked by the current MSB. Assumes HIGH_ZERO < HIGH_ONE < BIT_PERIOD.
module dshot_bit_shaper
    import dshot_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int HIGH_ONE  = 210,
    parameter int HIGH_ZERO = 105,
    parameter int SLOT_W    = 9
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_evt,
    input  logic                         bit_adv,
    input  logic                         in_frame,
    input  logic [SLOT_W-1:0]            slot,
    input  logic [NUM_CH*FRAME_BITS-1:0] frames,
    output logic [NUM_CH-1:0]            line
);

    localparam logic [SLOT_W-1:0] CMP_ONE  = SLOT_W'(HIGH_ONE);
    localparam logic [SLOT_W-1:0] CMP_ZERO = SLOT_W'(HIGH_ZERO);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        dframe_t sh_q;

        // Capture the frame at start, then move to the next bit each slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_q <= '0;
            end else if (start_evt) begin
                sh_q <= frames[ch*FRAME_BITS +: FRAME_BITS];
            end else if (bit_adv && in_frame) begin
                sh_q <= {sh_q[FRAME_BITS-2:0], 1'b0};
            end
        end

        // Compare the slot count with the selected high time.
        always_comb begin
            line[ch] = in_frame && (slot < (sh_q[FRAME_BITS-1] ? CMP_ONE : CMP_ZERO));
        end
    end

endmodule

// File: rtl/dshot_quad_tx.sv
// Module: dshot_quad_tx (top)
// Four-channel pulse-width-coded frame transmitter with a double-buffered
// value store, a shared timebase and a frame completion pulse.
// Assumes a synchronous active-low reset and IDLE_BITS >= 1.
module dshot_quad_tx
    import dshot_pkg::*;
#(
    parameter int NUM_CH     = 4,
    parameter int BIT_PERIOD = 280,
    parameter int HIGH_ONE   = 210,
    parameter int HIGH_ZERO  = 105,
    parameter int IDLE_BITS  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic [NUM_CH*VAL_W-1:0] load_values,
    output logic [NUM_CH-1:0]       dshot_out,
    output logic                    frame_done
);

    localparam int SLOT_W   = $clog2(BIT_PERIOD);
    localparam int BIT_SPAN = (IDLE_BITS > FRAME_BITS) ? IDLE_BITS : FRAME_BITS;
    localparam int BIT_W    = $clog2(BIT_SPAN);

    logic [SLOT_W-1:0]            slot;
    logic                         in_frame;
    logic                         bit_adv;
    logic                         start_evt;
    logic                         end_evt;
    logic [NUM_CH*VAL_W-1:0]      frame_values;
    logic [NUM_CH*FRAME_BITS-1:0] frames;
    logic                         done_q;

    dshot_timebase #(
        .BIT_PERIOD (BIT_PERIOD),
        .IDLE_BITS  (IDLE_BITS),
        .SLOT_W     (SLOT_W),
        .BIT_W      (BIT_W)
    ) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot      (slot),
        .in_frame  (in_frame),
        .bit_adv   (bit_adv),
        .start_evt (start_evt),
        .end_evt   (end_evt)
    );

    dshot_dbuf #(
        .NUM_CH (NUM_CH)
    ) u_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .load_values  (load_values),
        .start_evt    (start_evt),
        .frame_values (frame_values)
    );

    dshot_frame_enc #(
        .NUM_CH (NUM_CH)
    ) u_enc (
        .values (frame_values),
        .frames (frames)
    );

    dshot_bit_shaper #(
        .NUM_CH    (NUM_CH),
        .HIGH_ONE  (HIGH_ONE),
        .HIGH_ZERO (HIGH_ZERO),
        .SLOT_W    (SLOT_W)
    ) u_shape (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_evt (start_evt),
        .bit_adv   (bit_adv),
        .in_frame  (in_frame),
        .slot      (slot),
        .frames    (frames),
        .line      (dshot_out)
    );

    // Register the end-of-frame event as a one-clock completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= end_evt;
        end
    end

    assign frame_done = done_q;

endmodule

// File: rtl/dshot_quad_tx_chk.sv
// Module: dshot_quad_tx_chk
// Property checker bound into dshot_quad_tx. It relates the output lines and
// the completion pulse to the shared slot counter and frame phase.
module dshot_quad_tx_chk #(
    parameter int NUM_CH    = 4,
    parameter int SLOT_W    = 9,
    parameter int HIGH_ONE  = 210,
    parameter int HIGH_ZERO = 105
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] dshot_out,
    input logic              frame_done,
    input logic              in_frame,
    input logic              start_evt,
    input logic [SLOT_W-1:0] slot
);

    localparam logic [SLOT_W-1:0] CK_ONE  = SLOT_W'(HIGH_ONE);
    localparam logic [SLOT_W-1:0] CK_ZERO = SLOT_W'(HIGH_ZERO);

    // R6: lines stay low outside frames
    a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !in_frame |-> (dshot_out == '0));

    // R4: every bit is high for at least the short compare value
    a_r4_min_high: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && (slot < CK_ZERO)) |-> (dshot_out == '1));

    // R4: no line is high past the long compare value
    a_r4_late_low: assert property (@(posedge clk) disable iff (!rst_n)
        (slot >= CK_ONE) |-> (dshot_out == '0));

    // R5: lines rise only at the common slot start
    a_r5_rise_slot0: assert property (@(posedge clk) disable iff (!rst_n)
        (slot != '0) |-> ((dshot_out & ~$past(dshot_out)) == '0));

    // R6: a frame begins at slot zero right after the gap ends
    a_r6_start_enters: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (in_frame && (slot == '0)));

    // R10: completion pulse lasts one clock
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R10: completion pulse lands on the first idle clock
    a_r10_done_place: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (!in_frame && (slot == '0)));

    // R11: reset clears lines and the pulse
    a_r11_reset_clear: assert property (@(posedge clk)
        !rst_n |=> ((dshot_out == '0) && !frame_done));

endmodule

bind dshot_quad_tx dshot_quad_tx_chk #(
    .NUM_CH    (NUM_CH),
    .SLOT_W    (SLOT_W),
    .HIGH_ONE  (HIGH_ONE),
    .HIGH_ZERO (HIGH_ZERO)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dshot_out  (dshot_out),
    .frame_done (frame_done),
    .in_frame   (in_frame),
    .start_evt  (start_evt),
    .slot       (slot)
);

// File: tb/sim_dshot_quad_tx.sv
// Bench for dshot_quad_tx. A behavioural model gives the expected line levels
// and completion pulse on every falling edge. Frames are also decoded from
// the wire and compared with the values the sequence expects.
module sim_dshot_quad_tx;

    localparam int NCH      = 4;
    localparam int VW       = 11;
    localparam int FB       = 16;
    localparam int P        = 280;
    localparam int H1       = 210;
    localparam int H0       = 105;
    localparam int IDLE     = 2;
    localparam int IDLE_LEN = IDLE * P;
    localparam int T        = (FB + IDLE) * P;
    localparam int NFRM     = 7;
    localparam int MID      = 157;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load = 1'b0;
    logic [NCH*VW-1:0] load_values = '0;
    logic [NCH-1:0]    dshot_out;
    logic              frame_done;

    always #2 clk = ~clk;

    dshot_quad_tx #(
        .NUM_CH     (NCH),
        .BIT_PERIOD (P),
        .HIGH_ONE   (H1),
        .HIGH_ZERO  (H0),
        .IDLE_BITS  (IDLE)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .load_values (load_values),
        .dshot_out   (dshot_out),
        .frame_done  (frame_done)
    );

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    int t = 0;
    int done_seen = 0;
    logic [VW-1:0] m_front [NCH];
    logic [VW-1:0] m_back  [NCH];
    bit            m_pend;
    logic [FB-1:0] rx [NCH];
    logic [VW-1:0] exp_v [NFRM][NCH];
    string         exp_req [NFRM];

    function automatic logic [FB-1:0] mk_frame(input logic [VW-1:0] v);
        int x;
        int c;
        x = int'(v) << 5;
        c = (~(x ^ (x >> 4) ^ (x >> 8))) & 15;
        return {v, 1'b0, 4'(c)};
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h (t=%0d)", req, what, act, exp, t);
        end
    endtask

    // Model state: swap at the boundary edge, then take a same-edge load.
    always @(posedge clk) begin
        if (!rst_n) begin
            t = 0;
            m_pend = 1'b0;
            for (int i = 0; i < NCH; i++) begin
                m_front[i] = '0;
                m_back[i]  = '0;
            end
        end else begin
            if (((t % T) == IDLE_LEN - 1) && m_pend) begin
                for (int i = 0; i < NCH; i++) m_front[i] = m_back[i];
                m_pend = 1'b0;
            end
            if (load) begin
                for (int i = 0; i < NCH; i++) m_back[i] = load_values[i*VW +: VW];
                m_pend = 1'b1;
            end
            t = t + 1;
        end
    end

    // Per-cycle comparison and wire decoding on the falling edge.
    int            pos;
    int            fb;
    int            s;
    int            k;
    logic [NCH-1:0] e;
    logic [FB-1:0] f;
    string         req;
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            pos = t % T;
            e = '0;
            fb = 0;
            s = 0;
            if (pos >= IDLE_LEN) begin
                fb = (pos - IDLE_LEN) / P;
                s  = (pos - IDLE_LEN) % P;
                for (int ch = 0; ch < NCH; ch++) begin
                    f = mk_frame(m_front[ch]);
                    e[ch] = (s < (f[FB-1-fb] ? H1 : H0));
                end
            end
            if (pos < IDLE_LEN)  req = "R6";
            else if (fb < VW)    req = "R1";
            else if (fb == VW)   req = "R2";
            else                 req = "R3";
            check({req, "/R4"}, int'(dshot_out), int'(e), "line level");
            check("R10", int'(frame_done), int'(t > 0 && pos == 0), "frame_done");
            if (pos >= IDLE_LEN && s == 0)
                check("R5", int'(dshot_out), (1 << NCH) - 1, "aligned slot start");
            if (pos >= IDLE_LEN && s == MID)
                for (int ch = 0; ch < NCH; ch++) rx[ch][FB-1-fb] = dshot_out[ch];
            if (frame_done) done_seen++;
            if (t > 0 && pos == 0) begin
                k = t / T - 1;
                if (k < NFRM)
                    for (int ch = 0; ch < NCH; ch++)
                        check(exp_req[k], int'(rx[ch]), int'(mk_frame(exp_v[k][ch])), "decoded frame");
            end
        end
    end

    task automatic load_at(input int ta, input logic [NCH*VW-1:0] v);
        while (t != ta) @(negedge clk);
        load = 1'b1;
        load_values = v;
        @(negedge clk);
        load = 1'b0;
    endtask

    function automatic logic [NCH*VW-1:0] pack4(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                                input logic [VW-1:0] c, input logic [VW-1:0] d);
        return {d, c, b, a};
    endfunction

    logic [NCH*VW-1:0] va, vb, vc, vd, ve;

    initial begin
        va = pack4(11'h7FF, 11'h000, 11'h555, 11'h2AA);
        vb = pack4(11'h123, 11'h456, 11'h001, 11'h400);
        vc = pack4(11'h030, 11'h7FE, 11'h3C3, 11'h1FF);
        vd = pack4(11'h048, 11'h400, 11'h7FF, 11'h002);
        ve = pack4(11'h555, 11'h555, 11'h000, 11'h7FF);
        for (int ch = 0; ch < NCH; ch++) begin
            exp_v[0][ch] = '0;                   // R11: cleared buffers
            exp_v[1][ch] = va[ch*VW +: VW];      // R7
            exp_v[2][ch] = vc[ch*VW +: VW];      // R8: newest of two loads
            exp_v[3][ch] = vc[ch*VW +: VW];      // R9: boundary load deferred
            exp_v[4][ch] = vd[ch*VW +: VW];      // R9
            exp_v[5][ch] = ve[ch*VW +: VW];      // R7: load in idle gap
            exp_v[6][ch] = ve[ch*VW +: VW];      // R7: no load, no change
        end
        exp_req[0] = "R11";
        exp_req[1] = "R7";
        exp_req[2] = "R8";
        exp_req[3] = "R9";
        exp_req[4] = "R9";
        exp_req[5] = "R7";
        exp_req[6] = "R7";

        repeat (5) @(negedge clk);
        check("R11", int'(dshot_out), 0, "lines in reset");
        check("R11", int'(frame_done), 0, "frame_done in reset");
        rst_n = 1'b1;

        load_at(IDLE_LEN + 3000, va);
        load_at(IDLE_LEN + T + 1000, vb);
        load_at(IDLE_LEN + T + 2000, vc);
        load_at(IDLE_LEN + 3 * T - 1, vd);
        load_at(IDLE_LEN + 4 * T + FB * P + 100, ve);

        while (t != NFRM * T + 5) @(negedge clk);
        check("R10", done_seen, NFRM, "completion pulse count");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL R10 watchdog expired actual=%0d expected=%0d", done_seen, NFRM);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule